// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block sits in front of the serializer of one transmit lane of a video-style serial link. On every lane clock it produces one 10-bit symbol. Bit 0 is the first bit sent on the wire. A 2-bit mode input selects where the symbol comes from. The choices are the normal symbol stream arriving from the encoder, a PRBS7 stream for bit-error testing, a slow square wave of five zeros then five ones, or a fast alternating 1/0 pattern. The output is registered, so each symbol reflects the mode and data that were presented one clock earlier.

Going directly from the fast toggle to the slow toggle is an unsafe mode change. The block refuses to make it. When the mode input moves straight from 3 to 2, the block falls back to normal passthrough and stays there until the mode input returns to 0. It also raises a violation flag that stays set until reset. Only the direct step is blocked: a path through the PRBS mode or through normal mode is accepted.

Top module: `lane_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `symbol_o` becomes 0 and `seq_violation_o` becomes 0.
- R2: In normal mode (mode 0), `symbol_o` equals the `data_i` value that was sampled at the previous clock edge.
- R3: In PRBS mode (mode 1), each symbol holds the next 10 bits of a PRBS7 stream, with the earliest bit in bit 0. The generator is a 7-bit register s, seeded to 7'h7F by reset. Each bit is produced as s[6]^s[5], and that bit is then shifted in at s[0]. The stream advances 10 bits on every clock after reset, whatever mode is selected.
- R4: In slow toggle mode (mode 2), each symbol is 10'h3E0: bits 0 to 4 are 0 and bits 5 to 9 are 1. The pattern restarts from its first zero whenever the mode is entered.
- R5: In fast toggle mode (mode 3), each symbol is 10'h155: bit 0 is 1 and the bits then alternate.
- R6: A mode input of 2 that directly follows an accepted mode of 3 produces normal passthrough instead of the slow toggle, and it sets `seq_violation_o`.
- R7: After the event in R6, every nonzero mode input gives normal passthrough until a mode input of 0 is seen. The mode after that 0 takes effect normally.
- R8: Once `seq_violation_o` is set, it stays 1 until reset.
- R9: Moving from mode 3 to mode 2 through any intermediate accepted mode (1 or 0) is allowed and produces the slow toggle pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock, one symbol per cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Source select: 0 normal, 1 PRBS7, 2 slow toggle, 3 fast toggle |
| data_i | input | 10 | Normal symbol stream from the encoder |
| symbol_o | output | 10 | Registered output symbol, bit 0 sent first |
| seq_violation_o | output | 1 | Sticky flag set by a direct fast-to-slow toggle request |

## Verification
The bench aims at the direct step from 3 to 2. A design that ignored the guard would emit 10'h3E0 there, and one that forgot the flag would leave it low. While the block is locked out, the bench presents modes 1 and 3. A lock that cleared on any mode other than 0 would show up as a pattern instead of passthrough. The bench also takes the paths 3-1-2 and 3-0-2. An over-eager guard would block those legal changes. The PRBS checks run after long stretches in other modes, so a generator that only advanced while selected would fall out of phase with the model.

// File: rtl/lpg_pkg.sv
// Package: shared mode encoding for the lane test pattern generator.
package lpg_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL = 2'd0,
        MODE_PRBS   = 2'd1,
        MODE_SLOW   = 2'd2,
        MODE_FAST   = 2'd3
    } lpg_mode_e;
endpackage

// File: rtl/lpg_mode_ctrl.sv
// Module: lpg_mode_ctrl
// Decides which source is used this cycle. The decision is taken from the
// requested mode, the last accepted mode and the lock-out state.
// Assumes: mode_i is synchronous to clk; the choice is combinational so the
// top level can register the output with one cycle of latency.
module lpg_mode_ctrl
    import lpg_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic [1:0] mode_i,
    output lpg_mode_e sel_o,
    output logic      enter_o,
    output logic      locked_o,
    output logic      viol_o
);
    lpg_mode_e last_q;
    logic      lock_q;
    logic      viol_q;
    logic      bad_step;

    // Detect the forbidden direct step from fast to slow toggle.
    always_comb begin
        bad_step = (last_q == MODE_FAST) && (lpg_mode_e'(mode_i) == MODE_SLOW);
    end

    // Pick the effective source for this cycle.
    always_comb begin
        if (lock_q || bad_step) begin
            sel_o = MODE_NORMAL;
        end else begin
            sel_o = lpg_mode_e'(mode_i);
        end
        enter_o = (sel_o != last_q);
    end

    // Track the last accepted mode, the lock-out and the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= MODE_NORMAL;
            lock_q <= 1'b0;
            viol_q <= 1'b0;
        end else begin
            last_q <= sel_o;
            if (bad_step && !lock_q) begin
                lock_q <= 1'b1;
                viol_q <= 1'b1;
            end else if (lock_q && mode_i == 2'd0) begin
                lock_q <= 1'b0;
            end
        end
    end

    assign locked_o = lock_q;
    assign viol_o   = viol_q;

    // R6: a direct fast-to-slow request never selects the slow toggle
    p_no_direct_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (last_q == MODE_FAST && mode_i == 2'd2) |-> (sel_o == MODE_NORMAL));

    // R8: the violation flag is sticky
    p_viol_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        viol_q |=> viol_q);

    // R7: a nonzero request keeps the lock in place
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && mode_i != 2'd0) |=> lock_q);
endmodule

// File: rtl/lpg_prbs7.sv
// Module: lpg_prbs7
// PRBS7 generator (x^7 + x^6 + 1) that produces SYM_W bits per clock.
// Output bit 0 is the earliest bit. The register is seeded to all ones at
// reset and advances on every clock.
module lpg_prbs7 #(
    parameter int SYM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [SYM_W-1:0] bits_o
);
    localparam logic [6:0] SEED = 7'h7F;

    logic [6:0] state_q;
    logic [6:0] state_d;

    // Unroll SYM_W serial steps of the shift register.
    always_comb begin
        logic [6:0] s;
        logic       nb;
        s = state_q;
        bits_o = '0;
        for (int i = 0; i < SYM_W; i++) begin
            nb = s[6] ^ s[5];
            bits_o[i] = nb;
            s = {s[5:0], nb};
        end
        state_d = s;
    end

    // Advance the generator one symbol per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    // R3: the generator never locks up in the all-zero state
    p_prbs_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 7'd0);
endmodule

// File: rtl/lpg_toggle.sv
// Module: lpg_toggle
// Square-wave source with HALF bits at each level, starting at FIRST.
// The phase restarts at bit 0 when restart_i is high and advances by
// SYM_W bit times on each clock while active_i is high.
module lpg_toggle #(
    parameter int   SYM_W = 10,
    parameter int   HALF  = 5,
    parameter logic FIRST = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             restart_i,
    output logic [SYM_W-1:0] bits_o
);
    localparam int PERIOD = 2 * HALF;
    localparam int PH_W   = (PERIOD > 2) ? $clog2(PERIOD) : 1;

    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_d;

    // Build the symbol from the current phase.
    always_comb begin
        int start;
        start = restart_i ? 0 : int'(phase_q);
        for (int i = 0; i < SYM_W; i++) begin
            bits_o[i] = (((start + i) % PERIOD) < HALF) ? FIRST : ~FIRST;
        end
        phase_d = PH_W'((start + SYM_W) % PERIOD);
    end

    // Keep the phase while this pattern is in use.
    always_ff @(posedge clk) begin
        if (!rst_n)        phase_q <= '0;
        else if (active_i) phase_q <= phase_d;
    end

    // R4: the phase always stays inside one period
    p_phase_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(phase_q) < PERIOD);
endmodule

// File: rtl/lane_pattern_gen.sv
// Module: lane_pattern_gen
// Top level of the lane test pattern generator. It selects between the
// normal symbol stream, PRBS7, slow toggle and fast toggle, and registers
// the chosen symbol.
// Assumes: one symbol per clock, synchronous active-low reset.
module lane_pattern_gen
    import lpg_pkg::*;
#(
    parameter int SYM_W     = 10,
    parameter int SLOW_HALF = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic [SYM_W-1:0] data_i,
    output logic [SYM_W-1:0] symbol_o,
    output logic             seq_violation_o
);
    lpg_mode_e        sel;
    logic             enter;
    logic             locked;
    logic [SYM_W-1:0] prbs_bits;
    logic [SYM_W-1:0] slow_bits;
    logic [SYM_W-1:0] fast_bits;
    logic [SYM_W-1:0] symbol_d;

    lpg_mode_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (mode_i),
        .sel_o    (sel),
        .enter_o  (enter),
        .locked_o (locked),
        .viol_o   (seq_violation_o)
    );

    lpg_prbs7 #(.SYM_W(SYM_W)) u_prbs (
        .clk    (clk),
        .rst_n  (rst_n),
        .bits_o (prbs_bits)
    );

    lpg_toggle #(.SYM_W(SYM_W), .HALF(SLOW_HALF), .FIRST(1'b0)) u_slow (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (sel == MODE_SLOW),
        .restart_i (enter),
        .bits_o    (slow_bits)
    );

    lpg_toggle #(.SYM_W(SYM_W), .HALF(1), .FIRST(1'b1)) u_fast (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (sel == MODE_FAST),
        .restart_i (enter),
        .bits_o    (fast_bits)
    );

    // Choose the source for the next symbol.
    always_comb begin
        unique case (sel)
            MODE_PRBS: symbol_d = prbs_bits;
            MODE_SLOW: symbol_d = slow_bits;
            MODE_FAST: symbol_d = fast_bits;
            default:   symbol_d = data_i;
        endcase
    end

    // Register the output symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) symbol_o <= '0;
        else        symbol_o <= symbol_d;
    end

    // R7: while locked out, the output is the previous input data
    p_locked_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> symbol_o == $past(data_i));

    // R2: a normal-mode request outside lock-out passes data through
    p_normal_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0) |=> symbol_o == $past(data_i));
endmodule

// File: tb/lane_pattern_gen_bench.sv
module lane_pattern_gen_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic [9:0] data_i = 10'd0;
    logic [9:0] symbol_o;
    logic       seq_violation_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Reference model state
    logic [6:0] m_lfsr;
    logic [1:0] m_last;
    bit         m_lock;
    bit         m_viol;
    logic [9:0] exp_sym;
    bit         exp_viol;
    string      exp_tag;
    bit         pending = 1'b0;

    lane_pattern_gen u_lane_pattern_gen (
        .clk             (clk),
        .rst_n           (rst_n),
        .mode_i          (mode_i),
        .data_i          (data_i),
        .symbol_o        (symbol_o),
        .seq_violation_o (seq_violation_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [9:0] prbs_sym(input logic [6:0] s);
        logic [9:0] r;
        logic b;
        for (int i = 0; i < 10; i++) begin
            b = s[6] ^ s[5];
            r[i] = b;
            s = {s[5:0], b};
        end
        return r;
    endfunction

    function automatic logic [6:0] prbs_next(input logic [6:0] s);
        logic b;
        for (int i = 0; i < 10; i++) begin
            b = s[6] ^ s[5];
            s = {s[5:0], b};
        end
        return s;
    endfunction

    task automatic check(input logic [9:0] got, input logic [9:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Compare the previous expectation, then drive a new cycle
    task automatic step(input logic rst, input logic [1:0] m, input logic [9:0] d, input string tag_ovr);
        logic [1:0] sel;
        @(negedge clk);
        if (pending) begin
            check(symbol_o, exp_sym, exp_tag);
            check({9'd0, seq_violation_o}, {9'd0, exp_viol}, exp_viol ? "R8" : "R6");
        end
        rst_n = rst; mode_i = m; data_i = d;
        if (!rst) begin
            exp_sym = 10'd0; exp_viol = 1'b0; exp_tag = "R1";
            m_lfsr = 7'h7F; m_last = 2'd0; m_lock = 0; m_viol = 0;
        end else begin
            if (!m_lock && m_last == 2'd3 && m == 2'd2) begin
                m_lock = 1; m_viol = 1; sel = 2'd0; exp_tag = "R6";
            end else if (m_lock) begin
                sel = 2'd0; exp_tag = "R7";
                if (m == 2'd0) m_lock = 0;
            end else begin
                sel = m;
                case (m)
                    2'd0: exp_tag = "R2";
                    2'd1: exp_tag = "R3";
                    2'd2: exp_tag = "R4";
                    default: exp_tag = "R5";
                endcase
            end
            case (sel)
                2'd0: exp_sym = d;
                2'd1: exp_sym = prbs_sym(m_lfsr);
                2'd2: exp_sym = 10'h3E0;
                default: exp_sym = 10'h155;
            endcase
            m_lfsr = prbs_next(m_lfsr);
            m_last = sel;
            exp_viol = m_viol;
        end
        if (tag_ovr != "") exp_tag = tag_ovr;
        pending = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        step(1'b0, 2'd0, 10'd0, "R1");
        step(1'b0, 2'd0, 10'd0, "R1");
        // directed: each source
        step(1'b1, 2'd0, 10'h2A5, "");
        step(1'b1, 2'd0, 10'h15A, "");
        for (int i = 0; i < 5; i++) step(1'b1, 2'd1, 10'h3FF, "");
        step(1'b1, 2'd2, 10'h000, "");
        step(1'b1, 2'd2, 10'h000, "");
        step(1'b1, 2'd3, 10'h000, "");
        step(1'b1, 2'd3, 10'h000, "");
        // R6: forbidden direct step, then R7 lock-out held by modes 1,3,2
        step(1'b1, 2'd2, 10'h0F3, "R6");
        step(1'b1, 2'd1, 10'h1C7, "R7");
        step(1'b1, 2'd3, 10'h38E, "R7");
        step(1'b1, 2'd2, 10'h2B4, "R7");
        step(1'b1, 2'd0, 10'h111, "R7");
        step(1'b1, 2'd2, 10'h222, "R7");
        // R9: legal paths 3-1-2 and 3-0-2
        step(1'b1, 2'd3, 10'h000, "");
        step(1'b1, 2'd1, 10'h000, "R9");
        step(1'b1, 2'd2, 10'h000, "R9");
        step(1'b1, 2'd3, 10'h000, "");
        step(1'b1, 2'd0, 10'h3C3, "R9");
        step(1'b1, 2'd2, 10'h000, "R9");
        // R1: reset clears the sticky flag
        step(1'b0, 2'd3, 10'h3FF, "R1");
        step(1'b1, 2'd0, 10'h055, "");
        // random mix with long stretches in other modes before PRBS
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] m;
            m = 2'($urandom_range(0, 3));
            step(1'b1, m, 10'($urandom), "");
            if ($urandom_range(0, 9) == 0) begin
                for (int k = 0; k < int'($urandom_range(1, 6)); k++)
                    step(1'b1, m, 10'($urandom), "");
            end
        end
        step(1'b1, 2'd0, 10'h000, "");
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule